// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into host memory under the control of descriptors that live in that same memory. Each descriptor is four 32-bit words: a status/ownership word, a control word carrying the buffer size and linkage flags, the buffer address, and an optional next-descriptor pointer. The engine reads a descriptor, proceeds only if the host has handed it over, streams one frame into the buffer, and closes the descriptor by writing a single status word that returns it to the host.

The host steers the engine with a start bit, a base-address load that is honoured only while stopped, and a poll strobe that wakes the engine after it has parked on a descriptor the host still owns. A three-bit process-state output shows what the engine is doing at every cycle. Memory is a single synchronous port: a read returns its word one cycle after the request, and writes carry per-byte strobes.

Top module: `rxd_dma_engine`

## Requirements
- R1: After reset the process state is stopped (code 3'b000), no memory request is made and `s_ready` is low; raising `run_en` moves the engine to fetching on the next clock.
- R2: While fetching, the engine reads the four descriptor words at the current address (word k at address + 4k); if bit 31 of word 0 is 1 it moves to waiting for a frame and raises `s_ready`.
- R3: If bit 31 of word 0 is 0 the engine enters suspended (3'b100), makes no memory request, keeps `s_ready` low so stream bytes are not taken, and stays there until `poll_req`, which refetches the same descriptor address.
- R4: Frame bytes are packed little-endian (byte n goes to byte lane n mod 4 of the word at buffer address + 4*(n div 4)) using byte strobes, so memory bytes past the last stored byte are left untouched. The buffer address is word aligned.
- R5: The buffer size is word 1 bits 11:0. Bytes beyond it are accepted and dropped; such a frame is closed with bit 15 (error summary) set and the length field holding the number of bytes stored. A frame exactly the buffer size has no error.
- R6: Closing writes word 0 once, after all payload writes, as: bit 31 = 0, bit 9 = 1, bit 8 = 1, bits 29:16 = stored length, bit 15 = truncation, all other bits 0.
- R7: After closing, the next descriptor address is the base register when word 1 bit 15 is set; otherwise word 3 when word 1 bit 14 is set; otherwise the current address + 16.
- R8: A base-address load while stopped sets both the base register and the next descriptor to fetch. Clearing `run_en` while waiting or suspended returns to stopped; after closing with `run_en` low the engine stops instead of fetching.
- R9: The process state encodes stopped 3'b000, fetching 3'b001, waiting 3'b011, suspended 3'b100, closing 3'b101, writing 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start bit; low requests stop |
| base_wr | input | 1 | Load strobe for the base-address register |
| base_addr | input | 32 | Value loaded by `base_wr` |
| poll_req | input | 1 | Poll-demand strobe |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Engine takes a byte this cycle when valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| proc_state | output | 3 | Process state code |

## Verification
The bench aims at a frame whose length is not a multiple of four, where a design that wrote whole words would overwrite the byte after the frame, and at an overlong frame, where a design that did not stop at the buffer size would spill into the next region or report the offered length instead of the stored one. It walks a chained link, an unlinked contiguous step and an end-of-ring wrap, so a wrong next-address choice lands the status write at an address the scoreboard never sees. It parks the engine on a host-owned descriptor and offers bytes there, catching a design that takes data while suspended or wakes without a poll, and it reloads the base while stopped to catch a wrap that ignores the new base.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int DESC_STRIDE = DESC_WORDS * WORD_BYTES;

    // word 0 fields
    localparam int OWN_BIT = 31;
    localparam int ES_BIT  = 15;
    localparam int FS_BIT  = 9;
    localparam int LS_BIT  = 8;
    localparam int LEN_LSB = 16;
    localparam int LEN_W   = 14;
    // word 1 fields
    localparam int SIZE_W    = 12;
    localparam int CHAIN_BIT = 14;
    localparam int EOR_BIT   = 15;

    typedef enum logic [2:0] {
        PS_STOP  = 3'b000,
        PS_FETCH = 3'b001,
        PS_WAIT  = 3'b011,
        PS_SUSP  = 3'b100,
        PS_CLOSE = 3'b101,
        PS_WRITE = 3'b111
    } proc_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] bptr;
        logic [WORD_W-1:0] nptr;
    } desc_t;

    function automatic logic [WORD_W-1:0] pack_status(input logic trunc,
                                                      input logic [SIZE_W-1:0] len);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = LEN_W'(len);
        w[FS_BIT]  = 1'b1;
        w[LS_BIT]  = 1'b1;
        w[ES_BIT]  = trunc;
        w[OWN_BIT] = 1'b0;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] next_desc(input logic [WORD_W-1:0] cur,
                                                    input logic [WORD_W-1:0] base,
                                                    input desc_t d);
        if (d.ctl[EOR_BIT])        return base;
        else if (d.ctl[CHAIN_BIT]) return d.nptr;
        else                       return cur + WORD_W'(DESC_STRIDE);
    endfunction

endpackage

// File: rtl/rxd_desc_cache.sv
module rxd_desc_cache
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_v,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_data,
    output desc_t             desc
);
    logic [WORD_W-1:0] words [1:DESC_WORDS-1];

    for (genvar i = 1; i < DESC_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (cap_v && cap_idx == IDX_W'(i))
                words[i] <= cap_data;
        end
    end

    assign desc.ctl  = words[1];
    assign desc.bptr = words[2];
    assign desc.nptr = words[3];
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int OFF_W = SIZE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_v,
    input  logic [BYTE_W-1:0]     in_byte,
    input  logic [OFF_W-1:0]      in_off,
    input  logic                  in_flush,
    output logic                  out_v,
    output logic [WORD_W-1:0]     out_data,
    output logic [WORD_BYTES-1:0] out_strb,
    output logic [OFF_W-LANE_W-1:0] out_woff
);
    logic [WORD_W-1:0]       acc, nacc;
    logic [WORD_BYTES-1:0]   strb, nstrb;
    logic [OFF_W-LANE_W-1:0] woff, nwoff;
    logic [LANE_W-1:0]       lane;
    logic                    emit;

    assign lane = in_off[LANE_W-1:0];

    always_comb begin
        nacc  = acc;
        nstrb = strb;
        nwoff = woff;
        if (in_v) begin
            nacc[lane*BYTE_W +: BYTE_W] = in_byte;
            nstrb[lane] = 1'b1;
            nwoff = in_off[OFF_W-1:LANE_W];
        end
        emit = (in_v && lane == LANE_W'(WORD_BYTES-1)) || (in_flush && |nstrb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v    <= 1'b0;
            out_data <= '0;
            out_strb <= '0;
            out_woff <= '0;
            acc      <= '0;
            strb     <= '0;
            woff     <= '0;
        end else begin
            out_v <= emit;
            woff  <= nwoff;
            if (emit) begin
                out_data <= nacc;
                out_strb <= nstrb;
                out_woff <= nwoff;
                acc      <= '0;
                strb     <= '0;
            end else begin
                acc  <= nacc;
                strb <= nstrb;
            end
        end
    end

    // R4: a byte lane is never loaded twice before its word is written out
    p_lane_fresh_r4: assert property (@(posedge clk) disable iff (rst)
        in_v |-> !strb[lane]);
endmodule

// File: rtl/rxd_dma_engine.sv
module rxd_dma_engine
    import rxd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_en,
    input  logic                  base_wr,
    input  logic [WORD_W-1:0]     base_addr,
    input  logic                  poll_req,
    input  logic                  s_valid,
    input  logic [BYTE_W-1:0]     s_data,
    input  logic                  s_last,
    output logic                  s_ready,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [WORD_BYTES-1:0] mem_wstrb,
    output logic [WORD_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic [2:0]            proc_state
);
    proc_state_t        st;
    logic [WORD_W-1:0]  base_q, cur_q;
    logic [IDX_W:0]     fidx;
    logic               rd_v;
    logic [IDX_W-1:0]   rd_i;
    logic [SIZE_W-1:0]  cnt;
    logic               trunc_q, close_ph;
    desc_t              desc;
    logic [SIZE_W-1:0]  buf_size;
    logic               issue, accept, store;

    logic                     pk_v;
    logic [WORD_W-1:0]        pk_data;
    logic [WORD_BYTES-1:0]    pk_strb;
    logic [SIZE_W-LANE_W-1:0] pk_woff;

    logic unused_ctl;
    assign unused_ctl = ^{desc.ctl[WORD_W-1:EOR_BIT+1], desc.ctl[CHAIN_BIT-1:SIZE_W]};

    assign buf_size   = desc.ctl[SIZE_W-1:0];
    assign issue      = (st == PS_FETCH) && (fidx < (IDX_W+1)'(DESC_WORDS));
    assign s_ready    = (st == PS_WAIT && run_en) || (st == PS_WRITE);
    assign accept     = s_valid && s_ready;
    assign store      = accept && (cnt < buf_size);
    assign proc_state = st;

    rxd_desc_cache u_cache (
        .clk(clk), .rst(rst),
        .cap_v(rd_v && st == PS_FETCH), .cap_idx(rd_i), .cap_data(mem_rdata),
        .desc(desc)
    );

    rxd_packer #(.OFF_W(SIZE_W)) u_pack (
        .clk(clk), .rst(rst),
        .in_v(store), .in_byte(s_data), .in_off(cnt), .in_flush(accept && s_last),
        .out_v(pk_v), .out_data(pk_data), .out_strb(pk_strb), .out_woff(pk_woff)
    );

    // one memory port: payload flush, descriptor reads, status write-back
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wstrb = '0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (pk_v) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wstrb = pk_strb;
            mem_addr  = desc.bptr + WORD_W'({pk_woff, {LANE_W{1'b0}}});
            mem_wdata = pk_data;
        end else if (issue) begin
            mem_req  = 1'b1;
            mem_addr = cur_q + WORD_W'({fidx, {LANE_W{1'b0}}});
        end else if (st == PS_CLOSE && close_ph) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wstrb = '1;
            mem_addr  = cur_q;
            mem_wdata = pack_status(trunc_q, cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PS_STOP;
            base_q   <= '0;
            cur_q    <= '0;
            fidx     <= '0;
            rd_v     <= 1'b0;
            rd_i     <= '0;
            cnt      <= '0;
            trunc_q  <= 1'b0;
            close_ph <= 1'b0;
        end else begin
            rd_v <= issue;
            rd_i <= fidx[IDX_W-1:0];
            if (issue) fidx <= fidx + 1'b1;
            case (st)
                PS_STOP: begin
                    if (base_wr) begin
                        base_q <= base_addr;
                        cur_q  <= base_addr;
                    end
                    if (run_en) begin
                        st   <= PS_FETCH;
                        fidx <= '0;
                    end
                end
                PS_FETCH: begin
                    if (rd_v) begin
                        if (rd_i == '0 && !mem_rdata[OWN_BIT]) begin
                            st <= PS_SUSP;
                        end else if (rd_i == IDX_W'(DESC_WORDS-1)) begin
                            st      <= PS_WAIT;
                            cnt     <= '0;
                            trunc_q <= 1'b0;
                        end
                    end
                end
                PS_SUSP: begin
                    if (!run_en) begin
                        st <= PS_STOP;
                    end else if (poll_req) begin
                        st   <= PS_FETCH;
                        fidx <= '0;
                    end
                end
                PS_WAIT, PS_WRITE: begin
                    if (st == PS_WAIT && !run_en) begin
                        st <= PS_STOP;
                    end else if (accept) begin
                        if (store) cnt <= cnt + 1'b1;
                        else       trunc_q <= 1'b1;
                        st       <= s_last ? PS_CLOSE : PS_WRITE;
                        close_ph <= 1'b0;
                    end
                end
                PS_CLOSE: begin
                    if (!close_ph) begin
                        close_ph <= 1'b1;
                    end else begin
                        cur_q    <= next_desc(cur_q, base_q, desc);
                        st       <= run_en ? PS_FETCH : PS_STOP;
                        fidx     <= '0;
                        close_ph <= 1'b0;
                    end
                end
                default: st <= PS_STOP;
            endcase
        end
    end

    // R1: no memory traffic while stopped
    p_stop_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == PS_STOP) |-> !mem_req);
    // R3: suspended engine is silent on memory and holds without a poll
    p_susp_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PS_SUSP) |-> !mem_req);
    p_susp_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PS_SUSP && run_en && !poll_req) |=> (st == PS_SUSP));
    // R5: payload writes stay inside the buffer
    p_in_buffer_r5: assert property (@(posedge clk) disable iff (rst)
        pk_v |-> ({pk_woff, {LANE_W{1'b0}}} < buf_size));
    // R6: status word hands the descriptor back with first/last set
    p_wb_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (st == PS_CLOSE && mem_we && !pk_v) |-> (!mem_wdata[OWN_BIT] && mem_wdata[FS_BIT] && mem_wdata[LS_BIT]));
    // R6: no payload write is pending when the status goes out
    p_wb_last_r6: assert property (@(posedge clk) disable iff (rst)
        (st == PS_CLOSE && close_ph) |-> !pk_v);
endmodule

// File: tb/tb_rxd_dma_engine.sv
`timescale 1ns/1ps
module tb_rxd_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0, base_wr = 1'b0, poll_req = 1'b0;
    logic [31:0] base_addr = '0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, mem_req, mem_we;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  proc_state;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rxd_dma_engine dut (
        .clk(clk), .rst(rst), .run_en(run_en), .base_wr(base_wr), .base_addr(base_addr),
        .poll_req(poll_req), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_wstrb(mem_wstrb),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .proc_state(proc_state)
    );

    // memory model with a host-side write port
    logic [31:0] mem [0:1023];
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = '0, hw_data = '0;

    always @(posedge clk) begin
        if (hw_en) mem[hw_addr[11:2]] <= hw_data;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 7 + 1) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    // scoreboard
    typedef struct {
        logic [31:0] desc;
        logic [31:0] w0;
        logic [31:0] bufa;
        int          nst;
        int          seed;
    } exp_t;
    exp_t exq[$];

    task automatic send_frame(input logic [31:0] desc, input logic [31:0] bufa,
                              input int bsize, input int len, input int seed);
        exp_t e;
        int nst;
        nst = (len > bsize) ? bsize : len;
        e.desc = desc; e.bufa = bufa; e.nst = nst; e.seed = seed;
        e.w0 = (32'(nst) << 16) | 32'h0000_0300 | ((len > bsize) ? 32'h0000_8000 : 32'h0);
        exq.push_back(e);
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data  = pat(seed, i);
            s_last  = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    logic [31:0] last_fetch = '1;

    // monitor: pops one expected item per status write-back
    always @(negedge clk) begin
        if (!rst && mem_req && !mem_we && mem_addr[3:0] == 4'h0)
            last_fetch = mem_addr;
        if (!rst && mem_req && mem_we && mem_wstrb == 4'hF && exq.size() > 0 && mem_addr == exq[0].desc) begin
            exp_t e;
            e = exq.pop_front();
            // R5/R6: status word content, length and truncation flag
            check(mem_wdata == e.w0, "R6/R5 status word", mem_wdata, e.w0);
            // R9: write-back happens in closing state
            check(proc_state == 3'b101, "R9 closing code", 32'(proc_state), 32'h5);
            for (int i = 0; i < e.nst; i++)
                check(mem_byte(e.bufa + 32'(i)) == pat(e.seed, i), "R4 payload byte",
                      32'(mem_byte(e.bufa + 32'(i))), 32'(pat(e.seed, i)));
            // R4/R5: byte after the stored data untouched
            check(mem_byte(e.bufa + 32'(e.nst)) == 8'hEE, "R4/R5 byte past data",
                  32'(mem_byte(e.bufa + 32'(e.nst))), 32'hEE);
        end
    end

    task automatic wait_done();
        while (exq.size() != 0) @(negedge clk);
    endtask

    task automatic wait_code(input logic [2:0] c);
        while (proc_state != c) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // fill buffers with a sentinel, then build descriptors
        for (int a = 32'h400; a < 32'h800; a += 4) hw_write(32'(a), 32'hEEEE_EEEE);
        // D0: size 64, chained to 0x100
        hw_write(32'h000, 32'h8000_0000);
        hw_write(32'h004, 32'h0000_4000 | 32'd64);
        hw_write(32'h008, 32'h0000_0400);
        hw_write(32'h00C, 32'h0000_0100);
        // D1: size 20, no link flags (contiguous step to 0x110)
        hw_write(32'h100, 32'h8000_0000);
        hw_write(32'h104, 32'd20);
        hw_write(32'h108, 32'h0000_0500);
        hw_write(32'h10C, 32'h0000_0000);
        // D2: size 100, end of ring
        hw_write(32'h110, 32'h8000_0000);
        hw_write(32'h114, 32'h0000_8000 | 32'd100);
        hw_write(32'h118, 32'h0000_0600);
        hw_write(32'h11C, 32'h0000_0000);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(proc_state == 3'b000, "R1 reset state", 32'(proc_state), 32'h0);
        check(!s_ready && !mem_req, "R1 idle outputs", {30'd0, s_ready, mem_req}, 32'h0);

        base_wr = 1'b1; base_addr = 32'h000;
        @(negedge clk);
        base_wr = 1'b0; run_en = 1'b1;
        @(negedge clk);
        // R1/R9: fetching code after start
        check(proc_state == 3'b001, "R1/R9 fetching code", 32'(proc_state), 32'h1);
        wait_code(3'b011);
        // R2: owned descriptor reaches waiting with ready high
        check(s_ready == 1'b1, "R2 ready in waiting", 32'(s_ready), 32'h1);

        send_frame(32'h000, 32'h400, 64, 13, 1);   // partial last word (R4)
        wait_done();
        send_frame(32'h100, 32'h500, 20, 25, 2);   // chained link, truncation (R5, R7)
        wait_done();
        send_frame(32'h110, 32'h600, 100, 100, 3); // contiguous step, exact size (R5, R7)
        wait_done();

        wait_code(3'b100);
        // R7: end of ring returned to the base address
        check(last_fetch == 32'h000, "R7 wrap to base", last_fetch, 32'h0);
        // R3: bytes offered while suspended are not taken
        s_valid = 1'b1; s_data = 8'h55; s_last = 1'b1;
        repeat (20) @(negedge clk);
        check(proc_state == 3'b100 && !s_ready, "R3 suspended holds",
              {28'd0, s_ready, proc_state}, 32'h4);
        s_valid = 1'b0; s_last = 1'b0;

        hw_write(32'h400, 32'hEEEE_EEEE);
        hw_write(32'h000, 32'h8000_0000);
        @(negedge clk);
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        // R3: poll refetches
        check(proc_state == 3'b001, "R3 poll refetch", 32'(proc_state), 32'h1);
        send_frame(32'h000, 32'h400, 64, 1, 4);   // lands in the same descriptor (R3)
        wait_done();

        wait_code(3'b100);
        run_en = 1'b0;
        @(negedge clk);
        // R8: start bit cleared returns to stopped
        check(proc_state == 3'b000, "R8 stop from suspended", 32'(proc_state), 32'h0);

        hw_write(32'h200, 32'h8000_0000);
        hw_write(32'h204, 32'h0000_8000 | 32'd8);
        hw_write(32'h208, 32'h0000_0700);
        hw_write(32'h20C, 32'h0000_0000);
        @(negedge clk);
        base_wr = 1'b1; base_addr = 32'h200;
        @(negedge clk);
        base_wr = 1'b0; run_en = 1'b1;
        send_frame(32'h200, 32'h700, 8, 5, 5);    // R8: new base used
        wait_done();
        wait_code(3'b100);
        // R7/R8: wrap follows the reloaded base
        check(last_fetch == 32'h200, "R7/R8 wrap to new base", last_fetch, 32'h200);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule